// File: doc/BRIEF.md
# Raster Scanline Counter with Line Interrupt

This block tracks which raster line of a 525-line video frame is being drawn. It shows that line to a processor through a small 8-bit register port. A timing generator elsewhere supplies three things: a one-cycle line-start pulse, a frame-start flag that marks the first line of a frame, and a field bit. The block keeps a full internal line number. From it the block derives a 9-bit visible count that software can poll. In interlaced mode each field steps the line number by two, so the low bit of the count tells which field is on screen.

The compare register has split semantics. A write to the line register loads the low eight bits of a 9-bit interrupt compare line, while a read of the same register returns the live count. Compare bit 8 is stored in bit 6 of the enable register. That register reads back exactly as written, so software can OR a new enable into it without losing or changing compare bit 8. When the line number reaches the compare value with the line source enabled, a pending flag is set. The interrupt output is the OR of every pending source that is also enabled. The other sources are plain event inputs sharing the same enable and status registers.

Top module: `raster_line_irq`

## Requirements
- R1: After reset the count, the enable register, the compare value and all pending flags are zero, and irq is low.
- R2: In progressive mode, a line-start pulse with frame-start loads line 0, and every other line-start pulse adds 1.
- R3: The visible count saturates at 511 and holds there for lines 511 up to 524 and beyond, until the next frame start.
- R4: In interlaced mode, frame start loads the field bit as the first line and every later line adds 2, so count bit 0 equals the field. The field bit is latched at frame start and read as bit 1 of address 3.
- R5: The count changes only on a line-start pulse; between pulses it reads the same value on every cycle.
- R6: A write to address 2 sets compare bits 7:0; a read of address 2 returns count bits 7:0, never the compare value. Address 3 bit 0 returns count bit 8.
- R7: A read of address 0 (enable) returns the last byte written there. Bit 6 of that byte is compare bit 8, and bits 0 to NUM_SRC-1 are the per-source enables (bit 0 = line source).
- R8: The line pending flag (status bit 0) is set at the line-start edge where the new full line number equals the 9-bit compare value, and only if enable bit 0 is set.
- R9: Writing 1 to a status bit (address 1) clears that pending flag. A new event in the same cycle wins over the clear.
- R10: irq is high exactly when some pending flag has its enable bit set. An event on src_evt[k] sets status bit k+1 whatever its enable.
- R11: Writes to address 3 have no effect on any readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| frame_start | input | 1 | With line_start, marks the first line of a frame |
| field_in | input | 1 | Current field (0 even, 1 odd), used at frame start |
| interlace | input | 1 | 1 selects interlaced counting |
| src_evt | input | NUM_SRC-1 | Event pulses for interrupt sources 1 and up |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (zero when bus_rd is low) |
| irq | output | 1 | Interrupt request |
| scan_line | output | 9 | Live visible count |
| field_out | output | 1 | Latched field bit |
| raster_sat | output | 1 | Count is held at its top value (sync lines) |

## Verification
The assertions take it for granted that line_start is a single-cycle pulse and that frame_start is only raised together with line_start. They also assume that interlace does not change in the cycle of a line step whose arithmetic they check. The stimulus drives every input at the falling clock edge through tasks that raise a strobe for exactly one cycle. Mode changes happen only between line pulses, so the step and parity checks see a settled mode.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_STATUS = 2'd1,
    RA_LINE   = 2'd2,
    RA_HIGH   = 2'd3
  } reg_addr_e;

  localparam int DATA_W     = 8;
  localparam int CMP_HI_BIT = 6;
endpackage

// File: rtl/rsl_line_counter.sv
module rsl_line_counter #(
  parameter int CNT_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start,
  input  logic                frame_start,
  input  logic                field_in,
  input  logic                interlace,
  output logic [CNT_W:0]      full_line,
  output logic [CNT_W:0]      next_line,
  output logic [CNT_W-1:0]    scan_cnt,
  output logic                field_q,
  output logic                sat
);
  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] FULL_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [FULL_W-1:0] full_q;
  logic [FULL_W-1:0] step;

  always_comb begin
    step = interlace ? FULL_W'(2) : FULL_W'(1);
    if (frame_start)
      next_line = {{(FULL_W-1){1'b0}}, interlace & field_in};
    else if (full_q > FULL_MAX - step)
      next_line = FULL_MAX;
    else
      next_line = full_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= '0;
      field_q <= 1'b0;
    end else if (line_start) begin
      full_q <= next_line;
      if (frame_start) field_q <= field_in;
    end
  end

  assign full_line = full_q;
  assign scan_cnt  = (full_q[FULL_W-1] != 1'b0) ? CNT_MAX : full_q[CNT_W-1:0];
  assign sat       = (scan_cnt == CNT_MAX);

  // R5: no line pulse, no change
  a_r5_hold_between_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(scan_cnt));
  // R2: progressive step of one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && !interlace && scan_cnt < CNT_W'(500))
      |=> scan_cnt == $past(scan_cnt) + 1'b1);
  // R3: held once at the top value
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && scan_cnt == CNT_MAX) |=> scan_cnt == CNT_MAX);
  // R4: parity follows field at interlaced frame start
  a_r4_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && frame_start && interlace) |=> scan_cnt[0] == $past(field_in));
endmodule

// File: rtl/rsl_line_match.sv
module rsl_line_match #(
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W:0]    next_line,
  input  logic [CNT_W-1:0]  cmp_line,
  input  logic              line_en,
  output logic              set_line
);
  logic hit;

  assign hit      = (next_line == {1'b0, cmp_line});
  assign set_line = load && line_en && hit;

  // R8: a line event needs the enable
  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    set_line |-> line_en);
endmodule

// File: rtl/rsl_regs.sv
module rsl_regs
  import rsl_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [CNT_W-1:0]     scan_cnt,
  input  logic                 field_q,
  input  logic                 set_line,
  input  logic [NUM_SRC-2:0]   src_evt,
  output logic [CNT_W-1:0]     cmp_line,
  output logic                 line_en,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq
);
  localparam int PEND_PAD = DATA_W - NUM_SRC;
  localparam int LO_W     = CNT_W - 1;
  localparam int HI_PAD   = DATA_W - 2;

  logic [DATA_W-1:0]  ien_q;
  logic [LO_W-1:0]    cmp_lo_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_set;
  logic [NUM_SRC-1:0] pend_clr;
  logic               wr_ien, wr_stat, wr_line;
  reg_addr_e          addr;

  assign addr    = reg_addr_e'(bus_addr);
  assign wr_ien  = bus_wr && (addr == RA_ENABLE);
  assign wr_stat = bus_wr && (addr == RA_STATUS);
  assign wr_line = bus_wr && (addr == RA_LINE);

  assign pend_set = {src_evt, set_line};
  assign pend_clr = wr_stat ? bus_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= '0;
      cmp_lo_q <= '0;
      pend_q   <= '0;
    end else begin
      if (wr_ien)  ien_q    <= bus_wdata;
      if (wr_line) cmp_lo_q <= bus_wdata[LO_W-1:0];
      pend_q <= (pend_q & ~pend_clr) | pend_set;
    end
  end

  assign cmp_line = {ien_q[CMP_HI_BIT], cmp_lo_q};
  assign line_en  = ien_q[0];
  assign irq      = |(pend_q & ien_q[NUM_SRC-1:0]);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (addr)
        RA_ENABLE: bus_rdata = ien_q;
        RA_STATUS: bus_rdata = {{PEND_PAD{1'b0}}, pend_q};
        RA_LINE:   bus_rdata = scan_cnt[LO_W-1:0];
        RA_HIGH:   bus_rdata = {{HI_PAD{1'b0}}, field_q, scan_cnt[CNT_W-1]};
        default:   bus_rdata = '0;
      endcase
    end
  end

  initial begin
    a_r7_fits: assert (NUM_SRC <= CMP_HI_BIT);
  end

  // R7: enable register holds the written byte
  a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> ien_q == $past(bus_wdata));
  // R9: clear without a coincident event empties the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !set_line) |=> !pend_q[0]);
  // R9: event wins over clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_line |=> pend_q[0]);
  // R10: nothing enabled, no request
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q[NUM_SRC-1:0] == '0) |-> !irq);
endmodule

// File: rtl/raster_line_irq.sv
module raster_line_irq
  import rsl_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_start,
  input  logic                 frame_start,
  input  logic                 field_in,
  input  logic                 interlace,
  input  logic [NUM_SRC-2:0]   src_evt,
  input  logic [1:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [7:0]           bus_rdata,
  output logic                 irq,
  output logic [CNT_W-1:0]     scan_line,
  output logic                 field_out,
  output logic                 raster_sat
);
  logic [CNT_W:0]   full_line;
  logic [CNT_W:0]   next_line;
  logic [CNT_W-1:0] scan_cnt;
  logic [CNT_W-1:0] cmp_line;
  logic             field_q, line_en, set_line, sat;

  rsl_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
    .field_in(field_in), .interlace(interlace), .full_line(full_line),
    .next_line(next_line), .scan_cnt(scan_cnt), .field_q(field_q), .sat(sat)
  );

  rsl_line_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .load(line_start), .next_line(next_line),
    .cmp_line(cmp_line), .line_en(line_en), .set_line(set_line)
  );

  rsl_regs #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .scan_cnt(scan_cnt), .field_q(field_q),
    .set_line(set_line), .src_evt(src_evt), .cmp_line(cmp_line),
    .line_en(line_en), .bus_rdata(bus_rdata), .irq(irq)
  );

  assign scan_line  = scan_cnt;
  assign field_out  = field_q;
  assign raster_sat = sat;

  // R8: the pending line flag only rises where the full line equals the compare
  a_r8_match_line: assert property (@(posedge clk) disable iff (!rst_n)
    set_line |=> full_line == {1'b0, $past(cmp_line)});
endmodule

// File: tb/raster_line_irq_bench.sv
module raster_line_irq_bench;
  localparam int CLK_NS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0, frame_start = 1'b0, field_in = 1'b0, interlace = 1'b0;
  logic [2:0] src_evt = '0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq, field_out, raster_sat;
  logic [8:0] scan_line;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  raster_line_irq u_raster_line_irq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
    .field_in(field_in), .interlace(interlace), .src_evt(src_evt),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq), .scan_line(scan_line),
    .field_out(field_out), .raster_sat(raster_sat)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_line(input logic fs, input logic fld);
    @(negedge clk);
    line_start = 1'b1; frame_start = fs; field_in = fld;
    @(negedge clk);
    line_start = 1'b0; frame_start = 1'b0;
  endtask

  task automatic do_lines(input int n);
    for (int i = 0; i < n; i++) do_line(1'b0, 1'b0);
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // kind(2) fs fld il addr(2) data(8) exp(8); kind 0 line, 1 write, 2 read
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R2 frame start
    {2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00}, // R2 line 0
    {2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00},
    {2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h02}, // R2 line 2
    {2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h41, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h41}, // R7 readback
    {2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 8'h05, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h02}, // R6 count not compare
    {2'd1, 1'b0, 1'b0, 1'b0, 2'd3, 8'hFF, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 8'h00}, // R11 write ignored
    {2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h00, 8'h00}, // R4 odd field
    {2'd2, 1'b0, 1'b0, 1'b1, 2'd3, 8'h00, 8'h02}, // R4 field bit
    {2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b1, 2'd2, 8'h00, 8'h03}, // R4 step 2
    {2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h20, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, 8'h20}, // R7 readback
    {2'd2, 1'b0, 1'b0, 1'b1, 2'd1, 8'h00, 8'h00}  // R10 nothing pending
  };

  initial begin : watchdog
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_rd(2'd2, rd); check("R1 count", {8'h0, rd}, 16'h0);
    do_rd(2'd0, rd); check("R1 enable", {8'h0, rd}, 16'h0);
    do_rd(2'd1, rd); check("R1 status", {8'h0, rd}, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      interlace = VEC[i][18];
      case (VEC[i][22:21])
        2'd0: do_line(VEC[i][20], VEC[i][19]);
        2'd1: do_wr(VEC[i][17:16], VEC[i][15:8]);
        default: begin
          do_rd(VEC[i][17:16], rd);
          check("vector", {8'h0, rd}, {8'h0, VEC[i][7:0]});
        end
      endcase
    end

    // R3 saturation
    interlace = 1'b0;
    do_wr(2'd0, 8'h00);
    do_line(1'b1, 1'b0);
    do_lines(510);
    do_rd(2'd2, rd); check("R3 line 510", {8'h0, rd}, 16'h00FE);
    do_line(1'b0, 1'b0);
    do_rd(2'd2, rd); check("R3 line 511 low", {8'h0, rd}, 16'h00FF);
    do_rd(2'd3, rd); check("R6 bit 8", {8'h0, rd}, 16'h0001);
    do_lines(13);
    check("R3 held at 524", {7'h0, scan_line}, 16'd511);
    check("R3 sat flag", {15'h0, raster_sat}, 16'h1);
    do_line(1'b1, 1'b0);
    check("R3 frame restart", {7'h0, scan_line}, 16'd0);

    // R5 stable between pulses
    do_lines(7);
    repeat (10) @(negedge clk);
    do_rd(2'd2, rd); check("R5 stable", {8'h0, rd}, 16'd7);

    // R8 match at line 300 (compare 0x12C, bit 8 through enable bit 6)
    do_wr(2'd2, 8'h2C);
    do_wr(2'd0, 8'h41);
    do_line(1'b1, 1'b0);
    do_lines(299);
    do_rd(2'd1, rd); check("R8 before match", {8'h0, rd}, 16'h0);
    check("R10 no irq yet", {15'h0, irq}, 16'h0);
    do_line(1'b0, 1'b0);
    do_rd(2'd1, rd); check("R8 match pending", {8'h0, rd}, 16'h1);
    check("R10 irq on", {15'h0, irq}, 16'h1);

    // R9 clear
    do_wr(2'd1, 8'h01);
    do_rd(2'd1, rd); check("R9 cleared", {8'h0, rd}, 16'h0);
    check("R9 irq off", {15'h0, irq}, 16'h0);

    // R7 read-modify-write keeps compare bit 8
    do_rd(2'd0, rd);
    do_wr(2'd0, rd | 8'h02);
    do_rd(2'd0, rd); check("R7 rmw", {8'h0, rd}, 16'h43);
    do_line(1'b1, 1'b0);
    do_lines(300);
    do_rd(2'd1, rd); check("R7 compare kept", {8'h0, rd}, 16'h1);
    do_wr(2'd1, 8'h01);

    // R8 disabled source does not pend
    do_wr(2'd0, 8'h40);
    do_line(1'b1, 1'b0);
    do_lines(300);
    do_rd(2'd1, rd); check("R8 disabled", {8'h0, rd}, 16'h0);

    // R10 other source pends while masked, then drives irq once enabled
    @(negedge clk); src_evt = 3'b001;
    @(negedge clk); src_evt = 3'b000;
    do_rd(2'd1, rd); check("R10 src pend", {8'h0, rd}, 16'h2);
    check("R10 masked", {15'h0, irq}, 16'h0);
    do_wr(2'd0, 8'h42);
    check("R10 enabled", {15'h0, irq}, 16'h1);
    do_wr(2'd1, 8'h02);
    check("R9 src cleared", {15'h0, irq}, 16'h0);

    // R9 event wins over same-cycle clear
    do_wr(2'd0, 8'h41);
    do_line(1'b1, 1'b0);
    do_lines(299);
    @(negedge clk);
    line_start = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk);
    line_start = 1'b0; bus_wr = 1'b0;
    do_rd(2'd1, rd); check("R9 set wins", {8'h0, rd}, 16'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule